// File: doc/BRIEF.md
# Pulse-Swallow Programmable Integer Divider

This block divides a fast input clock by a programmable integer using the pulse-swallow method. A dual-modulus prescaler counts input clocks in groups of either N or N+1. N is 32 in the low band and 47 in the high band. Two loadable down counters are clocked by the prescaler's terminal tick. The program counter is loaded with P and the swallow counter is loaded with S. While the swallow counter is non-zero, the prescaler is held in its high modulus. Once the swallow counter runs out, the prescaler drops to the low modulus for the rest of the P periods. When the program counter reaches its terminal count, both counters reload from the inputs. The output period is therefore N·P + S input clocks.

The control is a three-state machine. `ST_START` exists only after reset and loads the counters on the first clock. `ST_SWALLOW` selects the high modulus. `ST_MAIN` selects the low modulus.

The state machine has four transitions:
- START→SWALLOW or START→MAIN: the load taken on leaving reset. It goes to SWALLOW when the effective S is non-zero and to MAIN otherwise.
- SWALLOW→MAIN: the swallow count is exhausted on a prescaler tick.
- SWALLOW→(SWALLOW or MAIN): a reload.
- MAIN→(SWALLOW or MAIN): a reload.

A reload happens on the prescaler tick at which the program counter stands at 1. The programmed values are sampled only at a reload, so the period being counted is never disturbed.

Top module: `swallow_divider`

## Requirements
- R1: While `rst_n` is low, `div_out` and `mod_hi` are 0. The first rising clock edge after release loads P, S and the band.
- R2: Between two successive reloads (each reload is marked by the falling edge of `div_out`) exactly N·P + S input clocks pass. N is 32 when the latched `band_hi` is 0 and 47 when it is 1.
- R3: `mod_hi` = 1 means the high modulus (N+1). It is 1 from the reload for S·(N+1) input clocks, then 0 for the rest of the period.
- R4: With an effective S of 0, `mod_hi` stays 0 for the whole period.
- R5: `div_out` is 1 for exactly the final prescaler period of each division. That is N clocks, or N+1 clocks when the effective S equals the effective P.
- R6: An S above the band limit is clamped to the limit. The limit is 31 in the low band and 47 in the high band.
- R7: An S larger than the effective P is clamped to P.
- R8: A P value below 2 is treated as 2.
- R9: Changes to `p_word`, `s_word` and `band_hi` between reloads have no effect on the period in progress. The values held at the reload edge govern the next period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Fast input clock being divided |
| rst_n | input | 1 | Active-low synchronous reset |
| band_hi | input | 1 | Band choice: 0 selects 32/33, 1 selects 47/48 |
| p_word | input | 7 | Program count P |
| s_word | input | 6 | Swallow count S |
| div_out | output | 1 | Divided output, high during the last prescaler period |
| mod_hi | output | 1 | Prescaler modulus control, 1 for high modulus |

## Verification
The in-RTL properties watch structural invariants on every cycle:
- the prescaler count stays below its modulus;
- neither counter wraps;
- the swallow count never exceeds the program count and is non-zero while in SWALLOW;
- `mod_hi` may only fall, and `div_out` may only change, one cycle after a prescaler tick.

Only the bench can show the arithmetic results:
- the exact N·P + S period;
- the length of the high-modulus run;
- the output pulse width;
- the clamping of out-of-range P and S;
- the deferral of input changes to the next reload, measured across whole periods under directed and random programming.

// File: rtl/swallow_div_pkg.sv
package swallow_div_pkg;

    // Control state of the swallow divider.
    typedef enum logic [1:0] {
        ST_START   = 2'd0,   // after reset: first load pending
        ST_SWALLOW = 2'd1,   // high modulus while swallow count remains
        ST_MAIN    = 2'd2    // low modulus until program count ends
    } div_state_e;

endpackage

// File: rtl/dual_mod_prescaler.sv
module dual_mod_prescaler #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] modulus,
    output logic          tick
);

    logic [CW-1:0] count;

    // Terminal tick in the last clock of each prescaler period.
    assign tick = run && (count == modulus - CW'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (!run || tick) begin
            count <= '0;
        end else begin
            count <= count + CW'(1);
        end
    end

    // R2: the count never reaches or passes the modulus in force
    p_count_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (count < modulus))
        else $error("prescaler count out of range");

endmodule

// File: rtl/down_counter.sv
module down_counter #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] value
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (load) begin
            value <= load_val;
        end else if (dec) begin
            value <= value - W'(1);
        end
    end

    // R2: a decrement without a load never hits an empty counter
    p_no_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |-> (value != '0))
        else $error("down counter wrapped");

endmodule

// File: rtl/ratio_limiter.sv
module ratio_limiter #(
    parameter int PW       = 7,
    parameter int SW       = 6,
    parameter int P_MIN    = 2,
    parameter int S_MAX_LO = 31,
    parameter int S_MAX_HI = 47
) (
    input  logic          band_hi,
    input  logic [PW-1:0] p_raw,
    input  logic [SW-1:0] s_raw,
    output logic [PW-1:0] p_eff,
    output logic [SW-1:0] s_eff
);

    logic [SW-1:0] s_lim;
    logic [SW-1:0] s_band;

    always_comb begin
        // R8: floor on the program count
        p_eff  = (p_raw < PW'(P_MIN)) ? PW'(P_MIN) : p_raw;
        // R6: band-dependent ceiling on the swallow count
        s_lim  = band_hi ? SW'(S_MAX_HI) : SW'(S_MAX_LO);
        s_band = (s_raw > s_lim) ? s_lim : s_raw;
        // R7: swallow count may not exceed program count
        s_eff  = (PW'(s_band) > p_eff) ? SW'(p_eff) : s_band;
    end

    always_comb begin
        p_s_bounded_r6: assert ((s_eff <= s_lim) && (PW'(s_eff) <= p_eff))
            else $error("swallow count outside limits");
    end

endmodule

// File: rtl/swallow_divider.sv
module swallow_divider #(
    parameter int P_W      = 7,
    parameter int S_W      = 6,
    parameter int LO_BASE  = 32,
    parameter int HI_BASE  = 47,
    parameter int S_MAX_LO = 31,
    parameter int S_MAX_HI = 47,
    parameter int P_MIN    = 2
) (
    input  logic           clk_in,
    input  logic           rst_n,
    input  logic           band_hi,
    input  logic [P_W-1:0] p_word,
    input  logic [S_W-1:0] s_word,
    output logic           div_out,
    output logic           mod_hi
);

    import swallow_div_pkg::*;

    localparam int CW = $clog2(HI_BASE + 2);

    div_state_e     state, state_d, load_state;
    logic [P_W-1:0] p_eff, p_cnt;
    logic [S_W-1:0] s_eff, s_cnt;
    logic           band_q;
    logic           pre_tick;
    logic           reload;
    logic [CW-1:0]  modulus;

    ratio_limiter #(
        .PW(P_W), .SW(S_W), .P_MIN(P_MIN),
        .S_MAX_LO(S_MAX_LO), .S_MAX_HI(S_MAX_HI)
    ) u_limit (
        .band_hi (band_hi),
        .p_raw   (p_word),
        .s_raw   (s_word),
        .p_eff   (p_eff),
        .s_eff   (s_eff)
    );

    always_comb begin
        modulus = band_q ? CW'(HI_BASE) : CW'(LO_BASE);
        if (state == ST_SWALLOW) begin
            modulus = modulus + CW'(1);
        end
    end

    dual_mod_prescaler #(.CW(CW)) u_pre (
        .clk     (clk_in),
        .rst_n   (rst_n),
        .run     (state != ST_START),
        .modulus (modulus),
        .tick    (pre_tick)
    );

    down_counter #(.W(P_W)) u_pcnt (
        .clk      (clk_in),
        .rst_n    (rst_n),
        .load     (reload),
        .load_val (p_eff),
        .dec      (pre_tick),
        .value    (p_cnt)
    );

    down_counter #(.W(S_W)) u_scnt (
        .clk      (clk_in),
        .rst_n    (rst_n),
        .load     (reload),
        .load_val (s_eff),
        .dec      (pre_tick && (state == ST_SWALLOW)),
        .value    (s_cnt)
    );

    // Next-state logic
    always_comb begin
        reload     = (state == ST_START) || (pre_tick && (p_cnt == P_W'(1)));
        load_state = (s_eff != '0) ? ST_SWALLOW : ST_MAIN;
        state_d    = state;
        unique case (state)
            ST_START:   state_d = load_state;
            ST_SWALLOW: begin
                if (reload) begin
                    state_d = load_state;
                end else if (pre_tick && (s_cnt == S_W'(1))) begin
                    state_d = ST_MAIN;
                end
            end
            ST_MAIN: begin
                if (reload) begin
                    state_d = load_state;
                end
            end
            default:    state_d = ST_START;
        endcase
    end

    // State register
    always_ff @(posedge clk_in) begin
        if (!rst_n) begin
            state <= ST_START;
        end else begin
            state <= state_d;
        end
    end

    // Band latched with each reload (R9)
    always_ff @(posedge clk_in) begin
        if (!rst_n) begin
            band_q <= 1'b0;
        end else if (reload) begin
            band_q <= band_hi;
        end
    end

    // Outputs decoded from registers
    always_comb begin
        div_out = (state != ST_START) && (p_cnt == P_W'(1));
        mod_hi  = (state == ST_SWALLOW);
    end

    // R3: the modulus only drops at a prescaler period boundary
    p_mod_falls_on_tick_r3: assert property (@(posedge clk_in) disable iff (!rst_n)
        $fell(mod_hi) |-> $past(pre_tick))
        else $error("modulus dropped mid period");

    // R3: the high modulus is held only while swallow count remains
    p_swallow_nonzero_r3: assert property (@(posedge clk_in) disable iff (!rst_n)
        (state == ST_SWALLOW) |-> (s_cnt != '0))
        else $error("swallow state with empty count");

    // R5: the output pulse starts on a prescaler boundary
    p_div_rises_on_tick_r5: assert property (@(posedge clk_in) disable iff (!rst_n)
        $rose(div_out) |-> $past(pre_tick))
        else $error("output rose off boundary");

    // R9: a reload (output fall) happens only on a prescaler tick
    p_reload_on_tick_r9: assert property (@(posedge clk_in) disable iff (!rst_n)
        $fell(div_out) |-> $past(pre_tick))
        else $error("reload off boundary");

    // R7: remaining swallow count never exceeds remaining program count
    p_s_within_p_r7: assert property (@(posedge clk_in) disable iff (!rst_n)
        (state != ST_START) |-> (P_W'(s_cnt) <= p_cnt))
        else $error("swallow count exceeds program count");

    // R8: the program counter is never empty once running
    p_p_nonzero_r8: assert property (@(posedge clk_in) disable iff (!rst_n)
        (state != ST_START) |-> (p_cnt != '0))
        else $error("program counter empty while running");

endmodule

// File: tb/swallow_divider_test.sv
`timescale 1ns/1ps
module swallow_divider_test;

    logic       clk_in = 1'b0;
    logic       rst_n  = 1'b0;
    logic       band_hi = 1'b0;
    logic [6:0] p_word = '0;
    logic [5:0] s_word = '0;
    logic       div_out;
    logic       mod_hi;

    always #2.5 clk_in = ~clk_in;   // 200 MHz

    swallow_divider uut (
        .clk_in  (clk_in),
        .rst_n   (rst_n),
        .band_hi (band_hi),
        .p_word  (p_word),
        .s_word  (s_word),
        .div_out (div_out),
        .mod_hi  (mod_hi)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    int    cyc      = 0;
    int    last_rel = 0;
    int    reloads  = 0;
    int    mod_cnt  = 0;
    int    div_cnt  = 0;
    bit    prev_div = 1'b0;
    bit    timed_out = 1'b0;
    bit    lat_band;
    int    lat_p, lat_s;
    string cur_tag = "R2";
    string lat_tag = "R2";

    function automatic int base_of(bit b);
        return b ? 47 : 32;
    endfunction

    function automatic int eff_p(int p);
        return (p < 2) ? 2 : p;
    endfunction

    function automatic int eff_s(bit b, int p, int s);
        int v;
        v = s;
        if (v > (b ? 47 : 31)) v = b ? 47 : 31;
        if (v > eff_p(p)) v = eff_p(p);
        return v;
    endfunction

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic latch_inputs();
        lat_band = band_hi;
        lat_p    = int'(p_word);
        lat_s    = int'(s_word);
        lat_tag  = cur_tag;
    endtask

    task automatic step();
        int es, ep, b;
        @(negedge clk_in);
        cyc++;
        if (prev_div && !div_out) begin
            b  = base_of(lat_band);
            ep = eff_p(lat_p);
            es = eff_s(lat_band, lat_p, lat_s);
            check({"R2 period ", lat_tag}, cyc - last_rel, b * ep + es);
            check({"R3 mod run ", lat_tag}, mod_cnt, es * (b + 1));
            check({"R5 pulse ", lat_tag}, div_cnt, b + ((es == ep) ? 1 : 0));
            reloads++;
            last_rel = cyc;
            mod_cnt  = 0;
            div_cnt  = 0;
            latch_inputs();
            check({"R3 mod start ", lat_tag}, int'(mod_hi),
                  (eff_s(lat_band, lat_p, lat_s) != 0) ? 1 : 0);
        end
        mod_cnt += int'(mod_hi);
        div_cnt += int'(div_out);
        prev_div = div_out;
        if (!timed_out && ((cyc > 190000) || (cyc - last_rel > 12000))) begin
            timed_out = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
        end
    endtask

    task automatic run_reloads(int n);
        int target;
        target = reloads + n;
        while ((reloads < target) && !timed_out) step();
    endtask

    task automatic set_in(bit b, int p, int s, string tag);
        band_hi = b;
        p_word  = 7'(p);
        s_word  = 6'(s);
        cur_tag = tag;
    endtask

    task automatic rand_in();
        bit b;
        b = 1'($urandom_range(0, 1));
        if (b) set_in(b, int'($urandom_range(105, 122)), int'($urandom_range(0, 47)), "R9 random");
        else   set_in(b, int'($urandom_range(75, 78)),   int'($urandom_range(0, 31)), "R9 random");
    endtask

    initial begin
        void'($urandom(32'd20240611));
        set_in(1'b0, 75, 10, "R2 low");
        rst_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            step();
            check("R1 reset div_out", int'(div_out), 0);
            check("R1 reset mod_hi", int'(mod_hi), 0);
        end
        rst_n    = 1'b1;
        latch_inputs();
        last_rel = cyc + 1;
        step();
        check("R1 first load mod_hi", int'(mod_hi), 1);
        run_reloads(2);

        set_in(1'b1, 110, 20, "R2 high");
        run_reloads(2);
        set_in(1'b0, 76, 0, "R4 zero swallow");
        run_reloads(2);
        set_in(1'b1, 105, 0, "R4 zero swallow high");
        run_reloads(2);
        set_in(1'b0, 77, 40, "R6 low clamp");
        run_reloads(2);
        set_in(1'b1, 110, 63, "R6 high clamp");
        run_reloads(2);
        set_in(1'b1, 20, 30, "R7 clamp to P");
        run_reloads(2);
        set_in(1'b0, 3, 31, "R7 clamp to P low");
        run_reloads(2);
        set_in(1'b0, 0, 5, "R8 floor");
        run_reloads(2);
        set_in(1'b1, 1, 0, "R8 floor high");
        run_reloads(2);

        // R9: change right after a reload and during the output pulse
        set_in(1'b0, 75, 5, "R9 early change");
        run_reloads(2);
        set_in(1'b1, 120, 40, "R9 early change");
        run_reloads(1);
        while (!div_out && !timed_out) step();
        set_in(1'b0, 78, 31, "R9 late change");
        run_reloads(2);

        // Random programming, with occasional changes mid-period
        for (int k = 0; k < 14 && !timed_out; k++) begin
            rand_in();
            run_reloads(1);
            for (int j = 0; j < 600 && !timed_out; j++) begin
                step();
                if ($urandom_range(0, 299) == 0) rand_in();
            end
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule